// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches the four incoming handshake lines of a serial port: clear-to-send, data-set-ready, ring indicator and carrier detect. It presents them as one 8-bit status byte. Each pin is active low and asynchronous to the core clock. A two-stage synchronizer brings each pin into the clock domain. The synchronized levels appear in the upper nibble as active-high bits.

The lower nibble holds one sticky change flag per line. A flag is set when its line toggles. For the ring indicator, only the trailing edge sets the flag, which is the line going back to inactive. The flags stay set until software reads the status byte; that read clears all four. When the interrupt enable is high, the modem-status interrupt is asserted for as long as any flag is set, no matter how long ago the change happened.

A read returns the byte as it stands before the clear. If a line changes in the same cycle as a read, that change is not lost.

Top module: `modem_status_detect`

## Requirements
- R1: Each pin passes through two clocked stages. A pin change is not visible in rdata_o after the first rising edge. It is visible after the second rising edge.
- R2: rdata_o[4] shows clear-to-send, [5] data-set-ready, [6] ring indicator and [7] carrier detect. Each bit is 1 while its pin is low (active) and 0 while the pin is high.
- R3: A change in either direction on clear-to-send, data-set-ready or carrier detect sets rdata_o[0], [1] or [3] respectively. The flag is set on the rising edge after the new level appears in the upper nibble.
- R4: rdata_o[2] is set only when the ring indicator returns to inactive (pin goes high). The ring indicator becoming active leaves rdata_o[2] at 0.
- R5: A set change flag stays set for as long as no read occurs, however many cycles pass.
- R6: A rising edge with rd_i high clears all four change flags. The byte on rdata_o in that cycle is the value before the clear. The upper nibble is not affected.
- R7: If a flag's set condition and a read meet on the same edge, that flag ends up set. The other flags are cleared.
- R8: irq_o equals irq_en_i AND the OR of rdata_o[3:0]. It responds to irq_en_i in the same cycle. It falls in the cycle after a read that clears the last flag, unless a new change arrives.
- R9: After reset, all pins are treated as inactive: rdata_o is 8'h00 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_ni | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_ni | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_ni | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_ni | input | 1 | Carrier detect pin, active low, asynchronous |
| rd_i | input | 1 | Status read strobe, one cycle per read |
| rdata_o | output | 8 | Status byte: live levels in [7:4], change flags in [3:0] |
| irq_en_i | input | 1 | Modem-status interrupt enable |
| irq_o | output | 1 | Modem-status interrupt |

## Verification
A wrong synchronizer depth shows up as the upper nibble changing one edge too early or too late after a pin change. A wrong edge register shows up one edge later as a missing or spurious flag in the lower nibble, for example a ring flag on the leading edge. A flag register that drops its state, or that loses a change landing on a read, shows at the read following the event: the lower nibble reads wrong and irq_o is misplaced in the cycle after. Interrupt gating errors show in the same cycle that irq_en_i or a flag moves.

// File: rtl/msd_pkg.sv
package msd_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned SYNC_STAGES = 2;

  // bit index of each line in both nibbles
  localparam int unsigned IDX_CTS = 0;
  localparam int unsigned IDX_DSR = 1;
  localparam int unsigned IDX_RI  = 2;
  localparam int unsigned IDX_DCD = 3;

  typedef enum logic {
    EDGE_ANY  = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // R1: output only moves to what the previous stage held
  a_r1_sync_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_o) |-> (q_o == $past(stage_q[STAGES-2])));
endmodule

// File: rtl/msd_edge.sv
module msd_edge
  import msd_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_ANY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic set_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  if (KIND == EDGE_FALL) begin : g_fall
    assign set_o = prev_q & ~lvl_i;
    // R4: a rising level never requests a flag
    a_r4_no_lead_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_i |-> !set_o);
  end else begin : g_any
    assign set_o = prev_q ^ lvl_i;
  end
endmodule

// File: rtl/msd_flags.sv
module msd_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;

  // set has priority over the read clear
  always_comb begin
    flags_d = rd_i ? '0 : flags_q;
    flags_d = flags_d | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R6
  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (set_i == '0)) |=> (flags_o == '0));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R5
    a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[i] && !rd_i) |=> flags_o[i]);
    // R7
    a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && set_i[i]) |=> flags_o[i]);
  end
endmodule

// File: rtl/modem_status_detect.sv
module modem_status_detect
  import msd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cts_ni,
  input  logic       dsr_ni,
  input  logic       ri_ni,
  input  logic       dcd_ni,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  input  logic       irq_en_i,
  output logic       irq_o
);
  localparam int unsigned N = NUM_LINES;

  logic [N-1:0] pins_n;
  logic [N-1:0] sync_n;
  logic [N-1:0] live;
  logic [N-1:0] set;
  logic [N-1:0] flags;

  always_comb begin
    pins_n          = '1;
    pins_n[IDX_CTS] = cts_ni;
    pins_n[IDX_DSR] = dsr_ni;
    pins_n[IDX_RI]  = ri_ni;
    pins_n[IDX_DCD] = dcd_ni;
  end

  msd_sync #(
    .W      (N),
    .STAGES (SYNC_STAGES),
    .RST_VAL({N{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_n),
    .q_o   (sync_n)
  );

  assign live = ~sync_n;

  for (genvar i = 0; i < N; i++) begin : g_line
    msd_edge #(
      .KIND((i == IDX_RI) ? EDGE_FALL : EDGE_ANY)
    ) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (live[i]),
      .set_o (set[i])
    );
  end

  msd_flags #(.N(N)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .rd_i   (rd_i),
    .flags_o(flags)
  );

  assign rdata_o = {live, flags};
  assign irq_o   = irq_en_i & (|flags);

  // R8
  a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i);
  a_r8_irq_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && (rdata_o[3:0] != 4'h0)) |-> irq_o);
endmodule

// File: tb/sim_modem_status_detect.sv
module sim_modem_status_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       rd = 1'b0;
  logic       irq_en = 1'b1;
  logic [7:0] rdata;
  logic       irq;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  always #4 clk = ~clk;

  modem_status_detect u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .cts_ni  (cts_n),
    .dsr_ni  (dsr_n),
    .ri_ni   (ri_n),
    .dcd_ni  (dcd_n),
    .rd_i    (rd),
    .rdata_o (rdata),
    .irq_en_i(irq_en),
    .irq_o   (irq)
  );

  // {pins dcd,ri,dsr,cts (active low), expected rdata after 3 edges}
  localparam logic [11:0] VEC [8] = '{
    {4'b1110, 8'h11},
    {4'b1100, 8'h32},
    {4'b1000, 8'h70},
    {4'b1100, 8'h34},
    {4'b0100, 8'hB8},
    {4'b1111, 8'h0B},
    {4'b0000, 8'hFB},
    {4'b1111, 8'h0F}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] p);
    {dcd_n, ri_n, dsr_n, cts_n} = p;
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    edges(1);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    edges(2);
    // R9 reset state
    chk("R9 rdata", rdata, 8'h00);
    chk("R9 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    edges(3);
    chk("R9 idle after reset", rdata, 8'h00);

    // table: R2 R3 R4 R6 R8
    for (int v = 0; v < 8; v++) begin
      drive(VEC[v][11:8]);
      edges(3);
      chk("R2/R3/R4 vector", rdata, VEC[v][7:0]);
      chk("R8 irq on flags", {7'd0, irq}, {7'd0, |VEC[v][3:0]});
      do_read();
      chk("R6 read clears", rdata, {VEC[v][7:4], 4'h0});
      chk("R8 irq drops", {7'd0, irq}, 8'h00);
    end

    // R1 two-stage delay: pins all inactive now
    drive(4'b1110);
    edges(1);
    chk("R1 not after 1st edge", rdata, 8'h00);
    edges(1);
    chk("R1 after 2nd edge", rdata, 8'h10);
    edges(1);
    chk("R3 flag on 3rd edge", rdata, 8'h11);

    // R5 sticky over a long wait, R8 irq masked then enabled
    irq_en = 1'b0;
    edges(200);
    chk("R5 sticky", rdata, 8'h11);
    chk("R8 masked", {7'd0, irq}, 8'h00);
    irq_en = 1'b1;
    #1;
    chk("R8 late enable", {7'd0, irq}, 8'h01);

    // R7 change lands on read edge: bit0 cleared, bit1 kept
    drive(4'b1100);
    edges(2);
    rd = 1'b1;
    edges(1);
    rd = 1'b0;
    chk("R7 set wins", rdata, 8'h32);
    chk("R7 irq held", {7'd0, irq}, 8'h01);
    do_read();
    chk("R6 second read", rdata, 8'h30);

    // R4 ring leading edge alone gives no flag
    drive(4'b1000);
    edges(4);
    chk("R4 lead edge", rdata, 8'h70);
    chk("R4 irq quiet", {7'd0, irq}, 8'h00);

    finish_run();
  end
endmodule